// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Bank

This block keeps one sticky interrupt-request flag for each of ten DMA channels. A channel engine raises its flag with a single-cycle completion pulse. The flag then stays high and drives that channel's interrupt request line until software clears it.

Software sees the flags through two byte-wide registers on a simple single-cycle register bus. The lower five channels sit in one register and the upper five in the other. A flag is cleared by writing 0 to its bit. Writing 1 to a bit keeps that flag as it was, so software can clear any chosen subset of flags in one write without a read-modify-write. A clear strobe from the interrupt controller is also accepted at the boundary, but it has no effect on the flags.

Top module: `dma_irq_status`

## Requirements
- R1: While reset is asserted, and right after it is released, every flag and every `irqReq` bit is 0, and both registers read 0x00.
- R2: A 1 on `chDone[n]` in one cycle sets flag n at that clock edge. `irqReq[n]` follows flag n directly, with no extra cycle.
- R3: The register at address 0x0 carries channel n (n = 0..4) in `regRdData[n]`. The register at address 0x8 carries channel 5+k (k = 0..4) in `regRdData[k]`.
- R4: `regRdData[7:5]` always reads 0, and the value written to those bits changes nothing.
- R5: A write with data bit k equal to 0 clears the flag mapped to bit k of the addressed register. A bit written as 1 leaves its flag unchanged.
- R6: No write value ever sets a flag. Only `chDone` can set one.
- R7: `icClear` has no effect on any flag or any `irqReq` bit.
- R8: If a `chDone` pulse and a write-0 clear hit the same flag in the same cycle, the flag ends up set.
- R9: Any address other than 0x0 and 0x8 reads 0x00, and a write to such an address changes no flag.
- R10: A write to one register leaves the flags of the other register untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chDone | input | 10 | Per-channel completion pulse; sets the matching flag |
| icClear | input | 10 | Clear strobe from the interrupt controller; ignored by the flags |
| regAddr | input | 4 | Register byte address; 0x0 and 0x8 are mapped |
| regWrEn | input | 1 | Single-cycle write strobe |
| regWrData | input | 8 | Write data; a 0 bit clears the mapped flag |
| regRdData | output | 8 | Combinational read data of the addressed register |
| irqReq | output | 10 | Per-channel interrupt request, equal to the stored flag |

## Verification
The assertions treat `chDone`, `regWrEn`, `regAddr` and `regWrData` as fully synchronous. They only ever look at values sampled on rising edges, and they judge each flag's rise or fall against the pulse and write seen in the previous cycle. The bench respects this: it changes every input only on the falling edge, and it holds each completion pulse and each write for exactly one rising edge. The one cycle in which a set and a clear coincide is driven deliberately, so the flag that survives can be compared with the set-wins rule.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NUM_CH     = 10;
  localparam int NUM_REG    = 2;
  localparam int CH_PER_REG = NUM_CH / NUM_REG;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int REG_STRIDE = 8;

  // strobes from the bus decoder to the flag datapath
  typedef struct packed {
    logic [NUM_CH-1:0]  clrMask;  // flag to be cleared this cycle
    logic [NUM_REG-1:0] rdSel;    // register selected for read
  } ctrlStrobes_t;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output ctrlStrobes_t      strobes
);
  logic [NUM_REG-1:0] regHit;
  logic [NUM_CH-1:0]  clrVec;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_hit
    assign regHit[r] = (regAddr == ADDR_W'(r * REG_STRIDE));
  end

  // a zero in the written byte clears the matching channel of the hit register
  for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
    localparam int REG_IDX = c / CH_PER_REG;
    localparam int BIT_IDX = c % CH_PER_REG;
    assign clrVec[c] = regWrEn & regHit[REG_IDX] & ~regWrData[BIT_IDX];
  end

  assign strobes = '{clrMask: clrVec, rdSel: regHit};
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chDone,
  input  ctrlStrobes_t      strobes,
  output logic [NUM_CH-1:0] flags,
  output logic [DATA_W-1:0] rdData
);
  // hardware set has priority over a software clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= chDone | (flags & ~strobes.clrMask);
  end

  always_comb begin
    rdData = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (strobes.rdSel[r])
        rdData[CH_PER_REG-1:0] = rdData[CH_PER_REG-1:0] | flags[r*CH_PER_REG +: CH_PER_REG];
    end
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chDone,
  input  logic [NUM_CH-1:0] icClear,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [NUM_CH-1:0] irqReq
);
  ctrlStrobes_t      strobes;
  logic [NUM_CH-1:0] flags;
  logic              unusedIcClear;

  // the interrupt controller's clear must not reach the flags
  assign unusedIcClear = ^icClear;

  dma_irq_ctrl u_ctrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strobes  (strobes)
  );

  dma_irq_flags u_flags (
    .clk    (clk),
    .rstN   (rstN),
    .chDone (chDone),
    .strobes(strobes),
    .flags  (flags),
    .rdData (regRdData)
  );

  assign irqReq = flags;
endmodule

// File: rtl/dma_irq_status_checker.sv
module dma_irq_status_checker
  import dma_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chDone,
  input logic [NUM_CH-1:0] icClear,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [NUM_CH-1:0] irqReq
);
  logic [NUM_CH-1:0] mayClear;
  logic              unusedIc;

  assign unusedIc = ^icClear;

  always_comb begin
    mayClear = '0;
    if (regWrEn && regAddr == 4'h0) mayClear[4:0] = ~regWrData[4:0];
    if (regWrEn && regAddr == 4'h8) mayClear[9:5] = ~regWrData[4:0];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> irqReq == '0);

  assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    chDone != '0 |=> (irqReq & $past(chDone)) == $past(chDone));

  assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[7:5] == 3'b000);

  assert_fall_needs_zero_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (~irqReq & $past(irqReq) & ~$past(mayClear)) == '0);

  assert_no_sw_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqReq & ~$past(irqReq) & ~$past(chDone)) == '0);

  assert_unmapped_reads_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != 4'h0 && regAddr != 4'h8) |-> regRdData == '0);
endmodule

bind dma_irq_status dma_irq_status_checker u_chk (.*);

// File: tb/dma_irq_status_bench.sv
`timescale 1ns/1ps
module dma_irq_status_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] chDone = '0;
  logic [9:0] icClear = '0;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [9:0] irqReq;

  int errors = 0;
  int checks = 0;
  logic [9:0] expFlags = '0;

  always #2.5 clk = ~clk;

  dma_irq_status u_dma_irq_status (.*);

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic checkAll(input string req);
    logic [7:0] d;
    readReg(4'h0, d); check({req, " reg0"}, 16'(d), {8'h0, 3'b0, expFlags[4:0]});
    readReg(4'h8, d); check({req, " reg1"}, 16'(d), {8'h0, 3'b0, expFlags[9:5]});
    check({req, " irqReq"}, 16'(irqReq), 16'(expFlags));
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] m);
    @(negedge clk);
    chDone = m;
    @(negedge clk);
    chDone = '0;
    expFlags |= m;
  endtask

  task automatic clearAll();
    doWrite(4'h0, 8'hE0);
    doWrite(4'h8, 8'hE0);
    expFlags = '0;
  endtask

  task automatic tReset();
    @(negedge clk);
    check("R1 irq during reset", 16'(irqReq), 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");
  endtask

  task automatic tSetEach();
    for (int c = 0; c < 10; c++) begin
      pulse(10'(1) << c);
      checkAll("R2 R3 single set");
    end
    clearAll();
    checkAll("R5 clear all");
  endtask

  task automatic tSelectiveClear();
    pulse(10'h3FF);
    doWrite(4'h0, 8'b1111_0101);   // clear ch1 and ch3
    expFlags[1] = 1'b0; expFlags[3] = 1'b0;
    checkAll("R5 selective reg0");
    doWrite(4'h8, 8'b1110_1110);   // clear ch5 and ch9
    expFlags[5] = 1'b0; expFlags[9] = 1'b0;
    checkAll("R5 R10 selective reg1");
    doWrite(4'h0, 8'h00);          // reg0 all cleared, reg1 kept
    expFlags[4:0] = '0;
    checkAll("R10 reg1 untouched");
    clearAll();
  endtask

  task automatic tNoSwSet();
    doWrite(4'h0, 8'hFF);
    doWrite(4'h8, 8'hFF);
    checkAll("R6 write ones no set");
  endtask

  task automatic tPadBits();
    logic [7:0] d;
    pulse(10'h3FF);
    doWrite(4'h0, 8'h1F);          // pads zero, flags kept
    doWrite(4'h8, 8'h1F);
    checkAll("R4 pad write ignored");
    readReg(4'h0, d); check("R4 pad read", 16'(d[7:5]), 16'h0);
    clearAll();
  endtask

  task automatic tIcClear();
    pulse(10'h2A5);
    @(negedge clk); icClear = '1;
    @(negedge clk); @(negedge clk); icClear = '0;
    checkAll("R7 icClear ignored");
    clearAll();
  endtask

  task automatic tSetWins();
    pulse(10'h01F);
    @(negedge clk);
    chDone = 10'h004; regAddr = 4'h0; regWrData = 8'h00; regWrEn = 1'b1;
    @(negedge clk);
    chDone = '0; regWrEn = 1'b0;
    expFlags[4:0] = 5'b00100;
    checkAll("R8 set wins");
    clearAll();
  endtask

  task automatic tUnmapped();
    logic [7:0] d;
    pulse(10'h3FF);
    readReg(4'h4, d); check("R9 read 0x4", 16'(d), 16'h0);
    readReg(4'hC, d); check("R9 read 0xC", 16'(d), 16'h0);
    doWrite(4'h4, 8'h00);
    doWrite(4'h1, 8'h00);
    checkAll("R9 unmapped write");
    clearAll();
  endtask

  initial begin
    fork
      begin
        tReset();
        tSetEach();
        tSelectiveClear();
        tNoSwSet();
        tPadBits();
        tIcClear();
        tSetWins();
        tUnmapped();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule